// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This unit sits between a single upstream request port and a word-wide memory port. It watches for two alias windows. Each 32-bit word inside a window stands for one bit of a byte in a backing region. When the processor master reads an alias word, the unit reads the backing word and returns only the selected bit, as 0 or 1, in bit 0. When the processor writes an alias word, the unit runs a locked two-step sequence on the backing memory. It reads the word, then writes it back with only the selected bit replaced.

Every other request passes through in the same cycle with no change. This covers addresses outside both windows and any request from a non-processor master, whatever its address. The memory returns read data one cycle after a read request and never stalls. The upstream master holds its request until `up_ready` is high at a clock edge.

Top module: `bb_xlat`

## Requirements
- R1: A processor request whose address lies in 0x2200_0000..0x23FF_FFFF (backing base 0x2000_0000) or in 0x4200_0000..0x43FF_FFFF (backing base 0x4000_0000) is an alias access. Any address outside those two ranges, such as 0x21FF_FFFC or 0x2400_0000, passes through.
- R2: For an alias address A, the offset is off = A - window base. The target byte is backing base + off[24:5], and the bit number in that byte is off[4:2]. The memory is addressed at the target byte address with bits [1:0] cleared. The selected bit inside the 32-bit word is (byte address mod 4)*8 + bit number (little-endian).
- R3: An alias read is accepted in the cycle it is presented, with `up_ready`=1 and a memory read at the word address of R2. One cycle later `up_rvalid`=1 and `up_rdata` is 0x1 if the bit is set and 0x0 if it is clear.
- R4: An alias write takes two cycles. In the first cycle the unit issues a memory read of the target word, with `up_ready`=0. In the next cycle it issues a memory write to the same word with `up_ready`=1. The write data equals the word just read, with only the selected bit changed.
- R5: Only bit 0 of the alias write data sets the new bit value. All other write-data bits have no effect.
- R6: A pass-through request drives `mem_req`, `mem_write`, `mem_addr` and `mem_wdata` equal to the upstream values in the same cycle, with `up_ready`=1. A pass-through read returns `mem_rdata` unchanged on `up_rdata` one cycle later, with `up_rvalid`=1.
- R7: A request marked as not from the processor (`up_cpu`=0) is passed through as in R6, even when its address lies in an alias window.
- R8: After reset, with no request presented, `mem_req`, `mem_lock` and `up_rvalid` are 0.
- R9: `mem_lock` is 1 in both cycles of an alias write sequence and 0 at all other times. A locked read is always followed directly by a locked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | 1 = write, 0 = read |
| up_cpu | input | 1 | Request comes from the processor master |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_ready | output | 1 | Request accepted at this edge |
| up_rvalid | output | 1 | Read data valid |
| up_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory request |
| mem_write | output | 1 | Memory write enable |
| mem_lock | output | 1 | Bus held for a read-modify-write |
| mem_addr | output | 32 | Memory byte address (word aligned for alias traffic) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |

## Verification
Pass-through and the first alias-write step are combinational. They are checked 1 ns after the input change, inside the same cycle. The write step of an alias sequence is checked in the following cycle, at the same offset. Read results come one edge after acceptance. The driver pushes each expected read value into a queue when the request is accepted. A monitor pops the queue and compares the value on the falling edge of the cycle in which `up_rvalid` is high. The bench's own memory model shows the backing word after each sequence, read back through a pass-through read.

// File: rtl/bb_pkg.sv
// Shared constants and types for the bit-band alias translator.
// Assumes a 32-bit byte address space and 32-bit data words.
package bb_pkg;
    localparam int AW        = 32;               // address width
    localparam int DW        = 32;               // data width
    localparam int NREG      = 2;                // number of alias windows
    localparam int WIN_BITS  = 25;               // log2 of alias window size (32 MB)
    localparam int BIT_BITS  = $clog2(DW);       // bit index inside a word
    localparam int LANE_BITS = $clog2(DW / 8);   // byte lane inside a word
    localparam int IDX_LSB   = LANE_BITS;        // alias word index starts here
    localparam int BYTE_LSB  = LANE_BITS + 3;    // byte offset starts here in alias offset

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/bb_decode.sv
// Alias window decoder.
// Compares the address with every alias window. On a hit it returns the
// word-aligned backing address and the bit index inside that word.
// Assumes the windows do not overlap and are aligned to their size.
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [NREG-1:0][AW-1:0] WIN_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NREG-1:0][AW-1:0] TGT_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [AW-1:0]       addr,
    output logic                hit,
    output logic [AW-1:0]       word_addr,
    output logic [BIT_BITS-1:0] bitpos
);
    localparam int BOFF_W = WIN_BITS - BYTE_LSB;

    logic [NREG-1:0]          match;
    logic [NREG-1:0][AW-1:0]  byte_addr;
    logic [AW-1:0]            sel_byte;

    // One comparator and target-byte adder per window.
    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign match[g]     = (addr[AW-1:WIN_BITS] == WIN_BASE[g][AW-1:WIN_BITS]);
        assign byte_addr[g] = TGT_BASE[g] + AW'(addr[WIN_BITS-1:BYTE_LSB]);
    end

    // Select the target byte address of the matching window.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) sel_byte = sel_byte | byte_addr[i];
        end
    end

    assign hit       = |match;
    assign word_addr = {sel_byte[AW-1:LANE_BITS], {LANE_BITS{1'b0}}};
    assign bitpos    = {sel_byte[LANE_BITS-1:0], addr[IDX_LSB+2:IDX_LSB]};

    logic unused_ok;
    assign unused_ok = ^{addr[IDX_LSB-1:0], BOFF_W[0]};
endmodule

// File: rtl/bb_bitops.sv
// Single-bit extract and merge on a data word.
// Purely combinational. Assumes bitpos < DW.
module bb_bitops
    import bb_pkg::*;
(
    input  logic [DW-1:0]       word_in,
    input  logic [BIT_BITS-1:0] bitpos,
    input  logic                new_bit,
    output logic                bit_out,
    output logic [DW-1:0]       word_merged
);
    // Read the selected bit.
    assign bit_out = word_in[bitpos];

    // Replace only the selected bit.
    always_comb begin
        word_merged         = word_in;
        word_merged[bitpos] = new_bit;
    end
endmodule

// File: rtl/bb_rmw_seq.sv
// Request steering and read-modify-write sequencer.
// Passes non-alias traffic straight through. Turns alias reads into
// single-bit reads and alias writes into a locked read-then-write.
// Assumes memory read data arrives one cycle after the read request and
// the upstream master holds its request until up_ready.
module bb_rmw_seq
    import bb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_valid,
    input  logic                up_write,
    input  logic [AW-1:0]       up_addr,
    input  logic [DW-1:0]       up_wdata,
    input  logic                alias_hit,
    input  logic [AW-1:0]       tgt_addr,
    input  logic [BIT_BITS-1:0] tgt_bitpos,
    input  logic [DW-1:0]       merged_word,
    input  logic                sel_bit,
    input  logic [DW-1:0]       mem_rdata,
    output logic [BIT_BITS-1:0] bitpos_q,
    output logic                newbit_q,
    output logic                up_ready,
    output logic                up_rvalid,
    output logic [DW-1:0]       up_rdata,
    output logic                mem_req,
    output logic                mem_write,
    output logic                mem_lock,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata
);
    seq_state_t    state;
    logic [AW-1:0] word_q;
    logic          rvalid_q;
    logic          ralias_q;
    logic          take_alias;

    assign take_alias = (state == ST_IDLE) && up_valid && alias_hit;

    // Drive memory and upstream handshake for the current cycle.
    always_comb begin
        mem_req   = up_valid;
        mem_write = up_write;
        mem_addr  = up_addr;
        mem_wdata = up_wdata;
        mem_lock  = 1'b0;
        up_ready  = 1'b1;
        if (state == ST_WRITE) begin
            mem_req   = 1'b1;
            mem_write = 1'b1;
            mem_addr  = word_q;
            mem_wdata = merged_word;
            mem_lock  = 1'b1;
        end else if (take_alias) begin
            mem_write = 1'b0;
            mem_addr  = tgt_addr;
            mem_wdata = '0;
            if (up_write) begin
                mem_lock = 1'b1;
                up_ready = 1'b0;
            end
        end
    end

    // Sequencer state and captured alias fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            word_q   <= '0;
            bitpos_q <= '0;
            newbit_q <= 1'b0;
            rvalid_q <= 1'b0;
            ralias_q <= 1'b0;
        end else begin
            rvalid_q <= (state == ST_IDLE) && up_valid && !up_write;
            ralias_q <= take_alias && !up_write;
            if (take_alias) begin
                word_q   <= tgt_addr;
                bitpos_q <= tgt_bitpos;
                newbit_q <= up_wdata[0];
            end
            if (take_alias && up_write) state <= ST_WRITE;
            else                        state <= ST_IDLE;
        end
    end

    assign up_rvalid = rvalid_q;
    assign up_rdata  = ralias_q ? {{(DW-1){1'b0}}, sel_bit} : mem_rdata;
endmodule

// File: rtl/bb_xlat.sv
// Bit-band alias address translator, top level.
// Connects the window decoder, the sequencer and the bit operators.
// Only requests flagged as processor requests may use aliasing.
module bb_xlat
    import bb_pkg::*;
#(
    parameter logic [NREG-1:0][AW-1:0] WIN_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NREG-1:0][AW-1:0] TGT_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    input  logic          up_write,
    input  logic          up_cpu,
    input  logic [31:0]   up_addr,
    input  logic [31:0]   up_wdata,
    output logic          up_ready,
    output logic          up_rvalid,
    output logic [31:0]   up_rdata,
    output logic          mem_req,
    output logic          mem_write,
    output logic          mem_lock,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata
);
    logic                win_hit;
    logic [AW-1:0]       tgt_addr;
    logic [BIT_BITS-1:0] tgt_bitpos;
    logic [BIT_BITS-1:0] bitpos_q;
    logic                newbit_q;
    logic                sel_bit;
    logic [DW-1:0]       merged_word;

    bb_decode #(.WIN_BASE(WIN_BASE), .TGT_BASE(TGT_BASE)) u_decode (
        .addr      (up_addr),
        .hit       (win_hit),
        .word_addr (tgt_addr),
        .bitpos    (tgt_bitpos)
    );

    bb_bitops u_bitops (
        .word_in     (mem_rdata),
        .bitpos      (bitpos_q),
        .new_bit     (newbit_q),
        .bit_out     (sel_bit),
        .word_merged (merged_word)
    );

    bb_rmw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .up_valid    (up_valid),
        .up_write    (up_write),
        .up_addr     (up_addr),
        .up_wdata    (up_wdata),
        .alias_hit   (win_hit && up_cpu),
        .tgt_addr    (tgt_addr),
        .tgt_bitpos  (tgt_bitpos),
        .merged_word (merged_word),
        .sel_bit     (sel_bit),
        .mem_rdata   (mem_rdata),
        .bitpos_q    (bitpos_q),
        .newbit_q    (newbit_q),
        .up_ready    (up_ready),
        .up_rvalid   (up_rvalid),
        .up_rdata    (up_rdata),
        .mem_req     (mem_req),
        .mem_write   (mem_write),
        .mem_lock    (mem_lock),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );
endmodule

// File: rtl/bb_xlat_chk.sv
// Protocol checker for bb_xlat, bound to every instance.
// Watches only top-level ports.
module bb_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        up_valid,
    input logic        up_write,
    input logic        up_cpu,
    input logic [31:0] up_addr,
    input logic [31:0] up_wdata,
    input logic        up_ready,
    input logic        up_rvalid,
    input logic [31:0] up_rdata,
    input logic        mem_req,
    input logic        mem_write,
    input logic        mem_lock,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata
);
    // R9: a locked read is followed by a locked write.
    a_r9_lock_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !mem_write) |=> (mem_lock && mem_write && mem_req));

    // R4: the read step of a sequence stalls the master.
    a_r4_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !mem_write) |-> !up_ready);

    // R4: the write step changes at most one bit of the word just read.
    a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && mem_write) |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    // R4: the write step goes to the word that was read.
    a_r4_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !mem_write) |=> (mem_addr == $past(mem_addr)));

    // R7: non-processor requests are never translated.
    a_r7_other_master: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_cpu && !mem_lock) |-> (mem_addr == up_addr && up_ready && !mem_lock));

    // R6: an accepted read gives read data on the next cycle.
    a_r6_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !up_write && !mem_lock) |=> up_rvalid);

    // R8: no read data appears without a request.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> !up_rvalid);
endmodule

bind bb_xlat bb_xlat_chk u_chk (.*);

// File: tb/bb_xlat_tb.sv
// Scoreboard bench for bb_xlat with a behavioral one-cycle memory.
module bb_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0, up_write = 1'b0, up_cpu = 1'b1;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic        up_ready, up_rvalid;
    logic [31:0] up_rdata;
    logic        mem_req, mem_write, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int lock_cycles = 0;
    logic [31:0] model [logic [31:0]];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    bb_xlat u_dut (.*);

    // Behavioral memory: writes land at the edge, read data one cycle later.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_write) model[mem_addr] = mem_wdata;
            else mem_rdata <= model.exists(mem_addr) ? model[mem_addr] : 32'h0;
        end
        if (mem_lock) lock_cycles++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected read value when read data is valid.
    always @(negedge clk) begin
        if (rst_n && up_rvalid) begin
            if (exp_q.size() == 0) check("R3/R6 unexpected rvalid", 32'h1, 32'h0);
            else check(tag_q.pop_front(), up_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [31:0] alias_of(input logic [31:0] wbase, input logic [31:0] boff,
                                             input int bitn);
        return wbase + boff * 32 + 32'(bitn) * 4;
    endfunction

    // Pass-through access, checked in the same cycle (R6/R7).
    task automatic pass(input string tag, input logic wr, input logic cpu,
                        input logic [31:0] a, input logic [31:0] d);
        up_valid = 1'b1; up_write = wr; up_cpu = cpu; up_addr = a; up_wdata = d;
        #1;
        check({tag, " addr"}, mem_addr, a);
        check({tag, " ctl"}, {31'b0, mem_req & up_ready & (mem_write == wr) & !mem_lock}, 32'h1);
        if (wr) check({tag, " wdata"}, mem_wdata, d);
        else begin
            exp_q.push_back(model.exists(a) ? model[a] : 32'h0);
            tag_q.push_back({tag, " rdata"});
        end
        @(posedge clk); @(negedge clk);
        up_valid = 1'b0;
    endtask

    // Alias read: same-cycle accept, bit in bit 0 next cycle (R2/R3).
    task automatic aread(input string tag, input logic [31:0] a, input logic [31:0] word,
                         input int pos);
        logic [31:0] w;
        up_valid = 1'b1; up_write = 1'b0; up_cpu = 1'b1; up_addr = a; up_wdata = 32'hFFFF_FFFF;
        #1;
        check({tag, " R2 word addr"}, mem_addr, word);
        check({tag, " R3 accept"}, {31'b0, up_ready & mem_req & !mem_write & !mem_lock}, 32'h1);
        w = model.exists(word) ? model[word] : 32'h0;
        exp_q.push_back({31'b0, w[pos]});
        tag_q.push_back({tag, " R3 bit"});
        @(posedge clk); @(negedge clk);
        up_valid = 1'b0;
    endtask

    // Alias write: locked read, then locked merged write (R4/R5/R9).
    task automatic awrite(input string tag, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] word, input int pos);
        logic [31:0] w;
        up_valid = 1'b1; up_write = 1'b1; up_cpu = 1'b1; up_addr = a; up_wdata = d;
        #1;
        check({tag, " R4 read step"},
              {mem_req, mem_write, mem_lock, up_ready}, {1'b1, 1'b0, 1'b1, 1'b0});
        check({tag, " R2 addr"}, mem_addr, word);
        w = model.exists(word) ? model[word] : 32'h0;
        w[pos] = d[0];
        @(posedge clk); @(negedge clk); #1;
        check({tag, " R9 write step"},
              {mem_req, mem_write, mem_lock, up_ready}, {1'b1, 1'b1, 1'b1, 1'b1});
        check({tag, " R4 addr"}, mem_addr, word);
        check({tag, " R4/R5 data"}, mem_wdata, w);
        @(posedge clk); @(negedge clk);
        up_valid = 1'b0;
        #1 check({tag, " R9 lock released"}, {31'b0, mem_lock}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset req", {31'b0, mem_req}, 32'h0);
        check("R8 reset lock", {31'b0, mem_lock}, 32'h0);
        check("R8 reset rvalid", {31'b0, up_rvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        pass("R6 pass write", 1'b1, 1'b1, 32'h2000_0300, 32'hA5A5_0F0F);
        aread("R3 bit2 set", 32'h2200_6008, 32'h2000_0300, 2);
        aread("R3 byte1 bit4 clear", alias_of(32'h2200_0000, 32'h301, 4), 32'h2000_0300, 12);
        awrite("R4 set bit", alias_of(32'h2200_0000, 32'h301, 4), 32'hFFFF_FFF1, 32'h2000_0300, 12);
        awrite("R5 clear bit", 32'h2200_6008, 32'hFFFF_FFFE, 32'h2000_0300, 2);
        pass("R6 pass read", 1'b0, 1'b1, 32'h2000_0300, 32'h0);
        @(negedge clk);
        check("R4/R5 backing word", model[32'h2000_0300], 32'hA5A5_1F0B);

        pass("R1 periph preset", 1'b1, 1'b1, 32'h4000_1000, 32'h0000_0000);
        awrite("R1 periph bit31", 32'h4202_007C, 32'h0000_0001, 32'h4000_1000, 31);
        check("R1 periph word", model[32'h4000_1000], 32'h8000_0000);

        pass("R7 other master write", 1'b1, 1'b0, 32'h2200_6008, 32'h0000_1234);
        pass("R7 other master read", 1'b0, 1'b0, 32'h2200_6008, 32'h0);
        pass("R1 below window", 1'b0, 1'b1, 32'h21FF_FFFC, 32'h0);
        pass("R1 above window", 1'b0, 1'b1, 32'h2400_0000, 32'h0);

        pass("R2 preset top", 1'b1, 1'b1, 32'h200F_FFFC, 32'h8000_0000);
        aread("R2 window top", 32'h23FF_FFFC, 32'h200F_FFFC, 31);
        repeat (2) @(negedge clk);
        check("R9 lock cycle total", 32'(lock_cycles), 32'd6);
        check("R3 queue drained", 32'(exp_q.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule